// File: doc/BRIEF.md
# Virtually indexed, physically tagged direct-mapped cache

This block is a 4 KB direct-mapped cache with one 32-bit word per line. A processor presents a virtual address. The cache picks its line from the low twelve address bits, which a page translation never changes. In the same cycle the block sends the virtual page number to an external translation buffer. In the next cycle the returned physical frame number is compared with the stored tag, so the cache read and the translation overlap and add no serial delay.

A read that hits returns data in the cycle after acceptance, and a new request can be taken in that same cycle. Three other cases stall the processor:

- A read miss issues a read to memory at the physical address and fills the line from the returned word.
- Every write goes through to memory. A write that hits also updates the stored word. A write that misses allocates nothing.
- A translation miss holds the request until an external walker signals that the translation is in place, then replays the lookup.

Elaboration rejects any geometry in which the index and byte-offset bits together are wider than the page displacement.

Top module: `vipt_cache`

## Requirements
- R1: After reset, stall, resp_valid, mem_req_valid and tlb_req_valid are low, and every line is invalid, so the first read of any address goes to memory.
- R2: A request is accepted in a cycle where req_valid is high and stall is low. In that same cycle tlb_req_valid is high and tlb_vpn equals req_vaddr[31:12].
- R3: A read hit occurs when tlb_hit is high in the cycle after the lookup was issued, the line at vaddr[11:2] is valid and its tag equals tlb_pfn. In that cycle resp_valid is high, resp_rdata is the stored word and no memory request is made.
- R4: A read that hits the translation buffer and misses the cache holds a memory read at {tlb_pfn, vaddr[11:0]}. In the mem_ack cycle, resp_valid is high and resp_rdata equals mem_rdata. The line is then valid with that frame number as its tag.
- R5: Tags are physical. Two virtual pages mapped to one frame share a line and both hit. The same index reached through a different frame misses and replaces the line.
- R6: When tlb_hit is low in the lookup cycle, there is no memory request and no response, and stall stays high. In the cycle tlb_refill_done is high, the lookup is issued again with the same page number, and the access then completes.
- R7: Every write makes a memory write at the physical address with req_wdata, and resp_valid is high in the mem_ack cycle. A write hit updates the stored word. A write miss leaves the line unchanged, so a later read still misses.
- R8: stall is low when the block is idle and in a read-hit lookup cycle. It is high in every other cycle, from the lookup cycle up to and including the response cycle.
- R9: A request presented in a read-hit cycle is accepted in that cycle, so hits complete one per cycle.
- R10: mem_req_valid, mem_req_write, mem_paddr and mem_wdata stay unchanged from the first request cycle until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| stall | output | 1 | Processor must hold its request |
| resp_valid | output | 1 | Read data or write acknowledge |
| resp_rdata | output | 32 | Read data |
| tlb_req_valid | output | 1 | Translation lookup issued this cycle |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_hit | input | 1 | Translation found, valid the cycle after the lookup |
| tlb_pfn | input | 20 | Physical frame number, valid with tlb_hit |
| tlb_refill_done | input | 1 | Pulse: walker has installed the missing translation |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | 1 = memory write |
| mem_paddr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench aims at three cases:

- **Synonyms and same-index conflicts.** A design that tagged lines with virtual page bits would miss when a synonym page reads a line already fetched through the same frame. It would also wrongly hit when the same index is reached through another frame.
- **Translation misses.** A design that let a translation miss reach memory would present a memory request with a stale frame. One that did not replay the lookup on the refill pulse would hang.
- **Write policy and pipelining.** The bench confirms that a write miss leaves no line behind and that a write hit refreshes the stored word. It also confirms that back-to-back hits are accepted without a bubble and that memory requests hold stable under zero and multi-cycle latency.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOOKUP    = 3'd1,
        ST_XLAT_WAIT = 3'd2,
        ST_MEM_RD    = 3'd3,
        ST_MEM_WR    = 3'd4
    } vipt_state_e;

    // Line selection must come entirely from untranslated address bits.
    function automatic bit geometry_fits(input int idx_w, input int ofs_w, input int page_w);
        return (idx_w + ofs_w) <= page_w;
    endfunction

endpackage

// File: rtl/vipt_line_store.sv
module vipt_line_store #(
    parameter int LINES  = 1024,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [TAG_W-1:0]         rd_tag,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [DATA_W-1:0]        wr_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Valid bits carry reset; tag and data are qualified by them.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int TAG_W = 20
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             xlat_hit,
    input  logic [TAG_W-1:0] xlat_pfn,
    output logic             hit
);
    logic [TAG_W-1:0] bit_eq;

    for (genvar g = 0; g < TAG_W; g++) begin : g_bit
        assign bit_eq[g] = ~(line_tag[g] ^ xlat_pfn[g]);
    end

    assign hit = line_valid & xlat_hit & (&bit_eq);

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int VADDR_W     = 32,
    parameter int PFN_W       = 20,
    parameter int PAGE_OFS_W  = 12,
    parameter int CACHE_BYTES = 4096,
    parameter int LINE_BYTES  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [VADDR_W-1:0]            req_vaddr,
    input  logic [LINE_BYTES*8-1:0]       req_wdata,
    output logic                          stall,
    output logic                          resp_valid,
    output logic [LINE_BYTES*8-1:0]       resp_rdata,
    output logic                          tlb_req_valid,
    output logic [VADDR_W-PAGE_OFS_W-1:0] tlb_vpn,
    input  logic                          tlb_hit,
    input  logic [PFN_W-1:0]              tlb_pfn,
    input  logic                          tlb_refill_done,
    output logic                          mem_req_valid,
    output logic                          mem_req_write,
    output logic [PFN_W+PAGE_OFS_W-1:0]   mem_paddr,
    output logic [LINE_BYTES*8-1:0]       mem_wdata,
    input  logic                          mem_ack,
    input  logic [LINE_BYTES*8-1:0]       mem_rdata
);
    import vipt_pkg::*;

    localparam int DATA_W  = LINE_BYTES * 8;
    localparam int OFS_W   = $clog2(LINE_BYTES);
    localparam int LINES   = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W   = $clog2(LINES);
    localparam int VPN_W   = VADDR_W - PAGE_OFS_W;
    localparam int PADDR_W = PFN_W + PAGE_OFS_W;

    if (!geometry_fits(IDX_W, OFS_W, PAGE_OFS_W)) begin : g_bad_geometry
        $error("cache index and offset exceed the page displacement");
    end

    typedef struct packed {
        vipt_state_e       st;
        logic              wr;
        logic [VADDR_W-1:0] vaddr;
        logic [PFN_W-1:0]  pfn;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_IDLE, wr: 1'b0, vaddr: '0, pfn: '0, wdata: '0};

    ctl_t r_q, r_d;

    logic              line_valid;
    logic [PFN_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              line_hit;
    logic              in_lookup;
    logic              rd_hit;
    logic              can_accept;
    logic              accept;
    logic              store_we;
    logic [PFN_W-1:0]  store_tag;
    logic [DATA_W-1:0] store_data;
    logic [IDX_W-1:0]  cur_idx;

    assign cur_idx = r_q.vaddr[OFS_W +: IDX_W];

    vipt_line_store #(
        .LINES  (LINES),
        .TAG_W  (PFN_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (line_data),
        .wr_en    (store_we),
        .wr_idx   (cur_idx),
        .wr_tag   (store_tag),
        .wr_data  (store_data)
    );

    vipt_tag_match #(
        .TAG_W (PFN_W)
    ) match_i (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .xlat_hit   (in_lookup & tlb_hit),
        .xlat_pfn   (tlb_pfn),
        .hit        (line_hit)
    );

    always_comb begin
        r_d        = r_q;
        in_lookup  = (r_q.st == ST_LOOKUP);
        rd_hit     = in_lookup & line_hit & ~r_q.wr;
        can_accept = (r_q.st == ST_IDLE) | rd_hit;
        accept     = req_valid & can_accept;
        store_we   = 1'b0;
        store_tag  = tlb_pfn;
        store_data = r_q.wdata;

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st    = ST_LOOKUP;
                    r_d.wr    = req_write;
                    r_d.vaddr = req_vaddr;
                    r_d.wdata = req_wdata;
                end
            end
            ST_LOOKUP: begin
                if (!tlb_hit) begin
                    r_d.st = ST_XLAT_WAIT;
                end else begin
                    r_d.pfn = tlb_pfn;
                    if (r_q.wr) begin
                        r_d.st   = ST_MEM_WR;
                        store_we = line_hit;
                    end else if (line_hit) begin
                        if (accept) begin
                            r_d.st    = ST_LOOKUP;
                            r_d.wr    = req_write;
                            r_d.vaddr = req_vaddr;
                            r_d.wdata = req_wdata;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.st = ST_MEM_RD;
                    end
                end
            end
            ST_XLAT_WAIT: begin
                if (tlb_refill_done) begin
                    r_d.st = ST_LOOKUP;
                end
            end
            ST_MEM_RD: begin
                store_tag  = r_q.pfn;
                store_data = mem_rdata;
                if (mem_ack) begin
                    store_we = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_MEM_WR: begin
                if (mem_ack) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        stall         = ~can_accept;
        tlb_req_valid = accept | ((r_q.st == ST_XLAT_WAIT) & tlb_refill_done);
        tlb_vpn       = accept ? req_vaddr[VADDR_W-1:PAGE_OFS_W] : r_q.vaddr[VADDR_W-1:PAGE_OFS_W];
        mem_req_valid = (r_q.st == ST_MEM_RD) | (r_q.st == ST_MEM_WR);
        mem_req_write = (r_q.st == ST_MEM_WR);
        mem_paddr     = {r_q.pfn, r_q.vaddr[PAGE_OFS_W-1:0]};
        mem_wdata     = r_q.wdata;
        resp_valid    = rd_hit | (mem_req_valid & mem_ack);
        resp_rdata    = rd_hit ? line_data : mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int PADDR_W = 32,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall,
    input logic               tlb_req_valid,
    input logic               tlb_hit,
    input logic               resp_valid,
    input logic [DATA_W-1:0]  resp_rdata,
    input logic               mem_req_valid,
    input logic               mem_req_write,
    input logic [PADDR_W-1:0] mem_paddr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_ack,
    input logic [DATA_W-1:0]  mem_rdata
);

    assert_resp_from_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !mem_req_valid) |-> $past(tlb_req_valid));

    assert_read_fill_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && mem_ack) |-> (resp_valid && resp_rdata == mem_rdata));

    assert_xlat_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tlb_req_valid) && !tlb_hit) |-> (stall && !resp_valid && !mem_req_valid));

    assert_write_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_ack) |-> resp_valid);

    assert_no_mem_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |-> !mem_req_valid);

    assert_mem_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_write)
                                         && $stable(mem_paddr) && $stable(mem_wdata)));

endmodule

bind vipt_cache vipt_cache_chk #(
    .PADDR_W (PADDR_W),
    .DATA_W  (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .tlb_req_valid (tlb_req_valid),
    .tlb_hit       (tlb_hit),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_paddr     (mem_paddr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata)
);

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_wdata = '0;
    logic        stall;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        tlb_req_valid;
    logic [19:0] tlb_vpn;
    logic        tlb_hit = 1'b0;
    logic [19:0] tlb_pfn = '0;
    logic        tlb_refill_done = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [31:0] mem_paddr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state: line contents and backing memory.
    bit          m_valid [int];
    logic [19:0] m_tag   [int];
    logic [31:0] m_data  [int];
    logic [31:0] m_mem   [int];

    always #5 clk = ~clk;

    vipt_cache dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_vaddr       (req_vaddr),
        .req_wdata       (req_wdata),
        .stall           (stall),
        .resp_valid      (resp_valid),
        .resp_rdata      (resp_rdata),
        .tlb_req_valid   (tlb_req_valid),
        .tlb_vpn         (tlb_vpn),
        .tlb_hit         (tlb_hit),
        .tlb_pfn         (tlb_pfn),
        .tlb_refill_done (tlb_refill_done),
        .mem_req_valid   (mem_req_valid),
        .mem_req_write   (mem_req_write),
        .mem_paddr       (mem_paddr),
        .mem_wdata       (mem_wdata),
        .mem_ack         (mem_ack),
        .mem_rdata       (mem_rdata)
    );

    function automatic logic [19:0] page_map(input logic [19:0] vpn);
        case (vpn)
            20'h12345: return 20'h00ABC;
            20'h54321: return 20'h00ABC;
            20'h00777: return 20'h00DEF;
            20'h0A0A0: return 20'h00123;
            default:   return vpn ^ 20'h0F0F0;
        endcase
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] pa);
        int k = int'(pa >> 2);
        if (m_mem.exists(k)) return m_mem[k];
        return {pa[31:2], 2'b00} ^ 32'h5A5A_3C3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_check();
        #3;
        chk(!stall && !resp_valid && !mem_req_valid && !tlb_req_valid, "R8 idle",
            {stall, resp_valid, mem_req_valid, tlb_req_valid}, 0);
    endtask

    // One access; xlat_wait < 0 means translation hits first time.
    task automatic access(input bit wr, input logic [31:0] va, input logic [31:0] wd,
                          input int xlat_wait, input int lat);
        logic [19:0] vpn = va[31:12];
        logic [19:0] pfn = page_map(va[31:12]);
        int          idx = int'(va[11:2]);
        logic [31:0] pa  = {pfn, va[11:0]};
        bit          hit;
        logic [31:0] exp_rd;
        step();
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
        #3;
        chk(!stall, "R8 accept stall", stall, 0);
        chk(tlb_req_valid && tlb_vpn == vpn, "R2 lookup issue", {tlb_req_valid, tlb_vpn}, {1'b1, vpn});
        step();
        req_valid = 1'b0;
        if (xlat_wait >= 0) begin
            tlb_hit = 1'b0;
            #3;
            chk(stall && !resp_valid && !mem_req_valid, "R6 xlat miss",
                {stall, resp_valid, mem_req_valid}, 3'b100);
            for (int i = 0; i < xlat_wait; i++) begin
                step();
                #3;
                chk(stall && !resp_valid && !mem_req_valid && !tlb_req_valid, "R6 waiting",
                    {stall, resp_valid, mem_req_valid, tlb_req_valid}, 4'b1000);
            end
            step();
            tlb_refill_done = 1'b1;
            #3;
            chk(tlb_req_valid && tlb_vpn == vpn, "R6 replay", {tlb_req_valid, tlb_vpn}, {1'b1, vpn});
            step();
            tlb_refill_done = 1'b0;
        end
        tlb_hit = 1'b1;
        tlb_pfn = pfn;
        hit = m_valid.exists(idx) && m_tag[idx] == pfn;
        #3;
        if (!wr && hit) begin
            chk(resp_valid && resp_rdata == m_data[idx], "R3 read hit", resp_rdata, m_data[idx]);
            chk(!mem_req_valid, "R3 no memory on hit", mem_req_valid, 0);
            chk(!stall, "R8 hit stall", stall, 0);
            step();
            tlb_hit = 1'b0;
        end else begin
            chk(!resp_valid && stall, "R8 miss lookup", {resp_valid, stall}, 2'b01);
            if (wr && hit) m_data[idx] = wd;
            step();
            tlb_hit = 1'b0;
            tlb_pfn = '0;
            for (int i = 0; i < lat; i++) begin
                #3;
                chk(mem_req_valid && mem_req_write == wr && mem_paddr == pa, "R10 held request",
                    {mem_req_valid, mem_req_write, mem_paddr}, {1'b1, wr, pa});
                if (wr) chk(mem_wdata == wd, "R7 write data", mem_wdata, wd);
                chk(stall && !resp_valid, "R8 memory wait", {stall, resp_valid}, 2'b10);
                step();
            end
            exp_rd = mem_word(pa);
            mem_ack = 1'b1;
            mem_rdata = wr ? 32'h0 : exp_rd;
            #3;
            chk(mem_req_valid && mem_req_write == wr && mem_paddr == pa,
                wr ? "R7 write address" : "R4 read address",
                {mem_req_valid, mem_req_write, mem_paddr}, {1'b1, wr, pa});
            chk(resp_valid, wr ? "R7 write ack" : "R4 fill response", resp_valid, 1);
            if (!wr) chk(resp_rdata == exp_rd, "R4 fill data", resp_rdata, exp_rd);
            else     chk(mem_wdata == wd, "R7 write data", mem_wdata, wd);
            chk(stall, "R8 response cycle", stall, 1);
            if (wr) begin
                m_mem[int'(pa >> 2)] = wd;
            end else begin
                m_valid[idx] = 1'b1;
                m_tag[idx]   = pfn;
                m_data[idx]  = exp_rd;
            end
            step();
            mem_ack = 1'b0;
            mem_rdata = '0;
        end
        idle_check();
    endtask

    // Two reads presented back to back; both must hit in the model.
    task automatic pair_hits(input logic [31:0] va1, input logic [31:0] va2);
        int i1 = int'(va1[11:2]);
        int i2 = int'(va2[11:2]);
        step();
        req_valid = 1'b1; req_write = 1'b0; req_vaddr = va1;
        #3;
        chk(tlb_req_valid && tlb_vpn == va1[31:12], "R2 first issue", tlb_vpn, va1[31:12]);
        step();
        req_vaddr = va2;
        tlb_hit = 1'b1; tlb_pfn = page_map(va1[31:12]);
        #3;
        chk(resp_valid && resp_rdata == m_data[i1], "R9 first hit", resp_rdata, m_data[i1]);
        chk(!stall && tlb_req_valid && tlb_vpn == va2[31:12], "R9 second accepted",
            {stall, tlb_req_valid, tlb_vpn}, {1'b0, 1'b1, va2[31:12]});
        step();
        req_valid = 1'b0;
        tlb_pfn = page_map(va2[31:12]);
        #3;
        chk(resp_valid && resp_rdata == m_data[i2], "R9 second hit", resp_rdata, m_data[i2]);
        step();
        tlb_hit = 1'b0;
        idle_check();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #3;
        chk(!stall && !resp_valid && !mem_req_valid && !tlb_req_valid, "R1 reset outputs",
            {stall, resp_valid, mem_req_valid, tlb_req_valid}, 0);

        access(1'b0, 32'h1234_5010, 0, -1, 2);        // R1 cold miss, R4 fill
        access(1'b0, 32'h1234_5010, 0, -1, 0);        // R3 hit
        access(1'b0, 32'h5432_1010, 0, -1, 0);        // R5 synonym hit
        access(1'b0, 32'h0077_7010, 0, -1, 1);        // R5 other frame misses
        access(1'b0, 32'h1234_5010, 0, -1, 0);        // R5 replaced, misses again
        access(1'b1, 32'h1234_5010, 32'hDEAD_BEEF, -1, 1); // R7 write hit
        access(1'b0, 32'h5432_1010, 0, -1, 0);        // R7 updated word read back
        access(1'b1, 32'h0077_7020, 32'h0BAD_F00D, -1, 3); // R7 write miss
        access(1'b0, 32'h0077_7020, 0, -1, 2);        // R7 no allocate: misses
        access(1'b0, 32'h0077_7030, 0, 3, 1);         // R6 translation miss
        access(1'b0, 32'h0A0A_0FFC, 0, 0, 0);         // R6 immediate refill, R4 zero latency
        pair_hits(32'h1234_5010, 32'h0077_7020);       // R9

        for (int n = 0; n < 40; n++) begin
            logic [19:0] vp;
            logic [11:0] of;
            case ($urandom_range(0, 3))
                0: vp = 20'h12345;
                1: vp = 20'h54321;
                2: vp = 20'h00777;
                default: vp = 20'h0A0A0;
            endcase
            case ($urandom_range(0, 3))
                0: of = 12'h010;
                1: of = 12'h020;
                2: of = 12'hFFC;
                default: of = 12'h000;
            endcase
            access($urandom_range(0, 3) == 0, {vp, of}, $urandom,
                   ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 2)) : -1,
                   int'($urandom_range(0, 3)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule